// File: doc/BRIEF.md
# I2C Slave Sleep and Wake Sequencer

This block listens to an I2C bus as a slave and controls a low-power sleep state for the device behind it. It samples SCL and SDA with a faster system clock and finds start and stop conditions. It shifts in bytes and counts the clock pulses of each byte. It acknowledges only the bytes of one special command, which is made of three bytes. The first is a reserved code. The second is the device address word. After a repeated start, the third is a second reserved code. When the ACK of the third byte ends, the block goes to sleep.

While asleep, the block keeps watching the bus. An access that begins with a start and carries the device address starts a wake-up. The block does not acknowledge this access. A regulator recovery begins on the ninth SCL rising edge after the start. It then runs for a fixed number of system clocks. After that the block returns to standby and flags that normal reads and writes may proceed. Such an access must still begin with a new start. The read and write transfers themselves belong to other logic.

Top module: `i2c_slp_seq`

## Requirements
- R1: After reset the block is in standby: `standby_ready` is 1, and `asleep`, `recovering` and `sda_pull_low` are 0.
- R2: In standby, the block acknowledges the first byte after a start when its value is 0xF8. The block does not acknowledge any other first byte.
- R3: After an acknowledged 0xF8, the block acknowledges the next byte only when bits [7:4] are 1010 and bits [3:1] equal `strap_addr[2:0]`. Bit 0, the read/write bit, has no effect.
- R4: After an acknowledged address, a repeated start followed by 0x86 is acknowledged. `asleep` rises at the SCL falling edge that ends that ACK bit and stays high after a stop.
- R5: Any of these aborts the entry sequence: a first byte other than 0xF8, a non-matching address, a stop in place of the repeated start, or a third byte other than 0x86. After an abort the rest of the sequence gets no ACK and the block stays awake.
- R6: While asleep the block never drives SDA. An access whose address does not match leaves it asleep.
- R7: While asleep, a start followed by a matching address byte (read/write bit ignored) triggers recovery at the ninth SCL rising edge. At that point `asleep` falls and `recovering` stays high for exactly REC_CYCLES system clocks.
- R8: Exactly one of `asleep`, `recovering` and `standby_ready` is high at any time. After recovery, a new entry sequence that begins with a fresh start is handled as in R2 to R4.
- R9: Bus traffic during recovery, including a start followed by 0xF8, gets no ACK and does not change how long recovery lasts.
- R10: `sda_pull_low` is asserted only from the SCL falling edge after the 8th bit of an acknowledged byte until the next SCL falling edge. It is low while SCL is high for the 8th bit and low again after the 9th bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line (wired-AND bus level) |
| strap_addr | input | 3 | Device address strap pins |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low for an ACK |
| asleep | output | 1 | Device is in sleep |
| recovering | output | 1 | Regulator recovery timer running |
| standby_ready | output | 1 | Normal access is allowed |

## Verification
Each bus edge passes two synchroniser flops and one edge-detect flop. So any output moves on the third system clock edge after SCL or SDA changes. The bench holds every bus phase for six system clocks and samples outputs at falling clock edges late in each phase, well after that three-clock delay has settled. ACK is read in the middle of the ninth SCL high phase. `asleep` is read one phase after the ninth falling edge. Recovery length is measured by counting clocks with `recovering` high, from its rise to its fall, so the three-clock offset at the start does not affect the count.

// File: rtl/i2c_slp_pkg.sv
package i2c_slp_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY,
    ST_ADDR,
    ST_RS,
    ST_CMD,
    ST_ENTER,
    ST_SLEEP,
    ST_RECOVER
  } seq_state_t;

  // Device address header match: upper nibble fixed, next three bits strap
  function automatic logic addr_hit(input logic [6:0] hdr,
                                    input logic [3:0] nibble,
                                    input logic [2:0] strap);
    return (hdr[6:3] == nibble) && (hdr[2:0] == strap);
  endfunction

endpackage

// File: rtl/i2c_slp_sampler.sv
module i2c_slp_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic          scl_q, sda_q, scl_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_in};
      sda_sync <= {sda_sync[LAST-1:0], sda_in};
      scl_q    <= scl_sync[LAST];
      sda_q    <= sda_sync[LAST];
    end
  end

  assign scl_now   = scl_sync[LAST];
  assign sda_now   = sda_sync[LAST];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign bus_start = scl_now & scl_q & sda_q & ~sda_now;
  assign bus_stop  = scl_now & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/i2c_slp_shifter.sv
module i2c_slp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_bit,
  input  logic              ack_req,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              first_byte,
  output logic              ninth_rise,
  output logic              ack_end,
  output logic              sda_pull_low
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] shreg;
  logic              first_q, ack_pend, pull_q;

  assign byte_done    = scl_rise && (bit_cnt == LAST_BIT);
  assign byte_val     = {shreg, sda_bit};
  assign ninth_rise   = scl_rise && (bit_cnt == ACK_SLOT);
  assign ack_end      = scl_fall && pull_q;
  assign first_byte   = first_q;
  assign sda_pull_low = pull_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      first_q  <= 1'b0;
      ack_pend <= 1'b0;
      pull_q   <= 1'b0;
    end else if (bus_start || bus_stop) begin
      bit_cnt  <= '0;
      first_q  <= bus_start;
      ack_pend <= 1'b0;
      pull_q   <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (bit_cnt == ACK_SLOT) begin
          bit_cnt <= '0;
        end else begin
          shreg   <= {shreg[DATA_W-3:0], sda_bit};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (byte_done) begin
        first_q  <= 1'b0;
        ack_pend <= ack_req;
      end
      if (scl_fall) begin
        if (pull_q) begin
          pull_q   <= 1'b0;
          ack_pend <= 1'b0;
        end else if (bit_cnt == ACK_SLOT && ack_pend) begin
          pull_q <= 1'b1;
        end
      end
    end
  end

  // R10: the ACK drive only ever begins on an SCL falling edge
  assert_ack_starts_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall));
  // R10: the ACK drive ends on an SCL fall or a bus condition, never mid-phase
  assert_ack_ends_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_q) |-> $past(scl_fall || bus_start || bus_stop));

endmodule

// File: rtl/i2c_slp_rec_timer.sv
module i2c_slp_rec_timer #(
  parameter int REC_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(REC_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(REC_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R9: a running recovery is never restarted by bus traffic
  assert_no_reload_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: rtl/i2c_slp_ctrl.sv
module i2c_slp_ctrl
  import i2c_slp_pkg::*;
#(
  parameter logic [3:0] ADDR_NIBBLE = 4'b1010,
  parameter logic [7:0] ENTRY_CODE  = 8'hF8,
  parameter logic [7:0] SLEEP_CODE  = 8'h86
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_done,
  input  logic [7:0] byte_val,
  input  logic       first_byte,
  input  logic       ninth_rise,
  input  logic       ack_end,
  input  logic       rec_done,
  input  logic [2:0] strap_addr,
  output logic       ack_req,
  output logic       rec_load,
  output logic       asleep,
  output logic       recovering,
  output logic       standby_ready
);
  seq_state_t st, nxt;
  logic       wake_arm, hit;

  assign hit = addr_hit(byte_val[7:1], ADDR_NIBBLE, strap_addr);

  always_comb begin
    nxt      = st;
    ack_req  = 1'b0;
    rec_load = 1'b0;
    unique case (st)
      ST_STANDBY: if (byte_done && first_byte && byte_val == ENTRY_CODE) begin
        ack_req = 1'b1;
        nxt     = ST_ADDR;
      end
      ST_ADDR: begin
        if (bus_start || bus_stop) nxt = ST_STANDBY;
        else if (byte_done) begin
          ack_req = hit;
          nxt     = hit ? ST_RS : ST_STANDBY;
        end
      end
      ST_RS: begin
        if (bus_start)                  nxt = ST_CMD;
        else if (bus_stop || byte_done) nxt = ST_STANDBY;
      end
      ST_CMD: begin
        if (bus_start || bus_stop) nxt = ST_STANDBY;
        else if (byte_done) begin
          ack_req = (byte_val == SLEEP_CODE);
          nxt     = ack_req ? ST_ENTER : ST_STANDBY;
        end
      end
      ST_ENTER: begin
        if (ack_end)                    nxt = ST_SLEEP;
        else if (bus_start || bus_stop) nxt = ST_STANDBY;
      end
      ST_SLEEP: if (ninth_rise && wake_arm) begin
        rec_load = 1'b1;
        nxt      = ST_RECOVER;
      end
      ST_RECOVER: if (rec_done) nxt = ST_STANDBY;
      default: nxt = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_STANDBY;
      wake_arm <= 1'b0;
    end else begin
      st <= nxt;
      if (bus_start || bus_stop || ninth_rise)
        wake_arm <= 1'b0;
      else if (st == ST_SLEEP && byte_done && first_byte && hit)
        wake_arm <= 1'b1;
    end
  end

  assign asleep        = (st == ST_SLEEP);
  assign recovering    = (st == ST_RECOVER);
  assign standby_ready = !asleep && !recovering;

  // R4: sleep is entered only as an ACK clock ends
  assert_sleep_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(ack_end));
  // R7: recovery starts only on a ninth SCL rising edge
  assert_wake_on_ninth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> $past(ninth_rise));
  // R7: recovery ends only when the timer expires
  assert_rec_ends_on_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recovering) |-> $past(rec_done));
  // R8: the three status flags are mutually exclusive and complete
  assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({asleep, recovering, standby_ready}) == 1);

endmodule

// File: rtl/i2c_slp_seq.sv
module i2c_slp_seq #(
  parameter int         REC_CYCLES  = 300,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_NIBBLE = 4'b1010,
  parameter logic [7:0] ENTRY_CODE  = 8'hF8,
  parameter logic [7:0] SLEEP_CODE  = 8'h86
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_addr,
  output logic       sda_pull_low,
  output logic       asleep,
  output logic       recovering,
  output logic       standby_ready
);
  logic       sda_now, scl_rise, scl_fall, bus_start, bus_stop;
  logic       byte_done, first_byte, ninth_rise, ack_end;
  logic [7:0] byte_val;
  logic       ack_req, rec_load, rec_busy, rec_done;

  i2c_slp_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_slp_shifter #(.DATA_W(8)) u_shifter (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_bit(sda_now),
    .ack_req(ack_req), .byte_done(byte_done), .byte_val(byte_val),
    .first_byte(first_byte), .ninth_rise(ninth_rise), .ack_end(ack_end),
    .sda_pull_low(sda_pull_low)
  );

  i2c_slp_ctrl #(
    .ADDR_NIBBLE(ADDR_NIBBLE), .ENTRY_CODE(ENTRY_CODE), .SLEEP_CODE(SLEEP_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_done(byte_done), .byte_val(byte_val), .first_byte(first_byte),
    .ninth_rise(ninth_rise), .ack_end(ack_end), .rec_done(rec_done),
    .strap_addr(strap_addr), .ack_req(ack_req), .rec_load(rec_load),
    .asleep(asleep), .recovering(recovering), .standby_ready(standby_ready)
  );

  i2c_slp_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(rec_load), .busy(rec_busy), .done(rec_done)
  );

  // R6, R9: SDA is left alone while asleep or recovering
  assert_quiet_when_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep || recovering) |-> !sda_pull_low);
  // R7: the recovering flag tracks the running timer
  assert_flag_matches_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recovering == rec_busy);

endmodule

// File: tb/i2c_slp_seq_tb.sv
module i2c_slp_seq_tb;
  localparam int REC = 300;
  localparam int H   = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, asleep, recovering, standby_ready;
  logic sda_wire;
  int   checks = 0, fails = 0, rec_seen = 0;

  always #4 clk = ~clk;
  assign sda_wire = sda_m & ~sda_pull_low;

  i2c_slp_seq #(.REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_wire),
    .strap_addr(STRAP), .sda_pull_low(sda_pull_low), .asleep(asleep),
    .recovering(recovering), .standby_ready(standby_ready)
  );

  always @(negedge clk) if (rst_n && recovering) rec_seen++;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(H);
    scl_m = 1'b1; wait_cyc(H);
    sda_m = 1'b0; wait_cyc(H);
    scl_m = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(H);
    scl_m = 1'b1; wait_cyc(H);
    sda_m = 1'b1; wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked,
                           output logic early, output logic late);
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H);
      if (i == 0) early = sda_pull_low;
      scl_m = 1'b0; wait_cyc(H);
    end
    sda_m = 1'b1; wait_cyc(H);
    scl_m = 1'b1; wait_cyc(H / 2);
    acked = sda_pull_low;
    wait_cyc(H - H / 2);
    scl_m = 1'b0; wait_cyc(H);
    late = sda_pull_low;
  endtask

  function automatic logic [7:0] dev_word(input logic [2:0] strap, input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic t_reset();
    check(standby_ready, 1, "R1 standby_ready after reset");
    check(asleep,        0, "R1 asleep after reset");
    check(recovering,    0, "R1 recovering after reset");
    check(sda_pull_low,  0, "R1 sda_pull_low after reset");
  endtask

  task automatic t_enter(input logic rw);
    logic a, e, l;
    bus_start();
    send_byte(8'hF8, a, e, l);
    check(a, 1, "R2 entry code acked");
    check(e, 0, "R10 no pull during 8th bit high");
    check(l, 0, "R10 pull released after 9th bit");
    send_byte(dev_word(STRAP, rw), a, e, l);
    check(a, 1, "R3 device address acked");
    bus_start();
    send_byte(8'h86, a, e, l);
    check(a, 1, "R4 sleep code acked");
    check(l, 0, "R10 pull released after sleep ack");
    check(asleep, 1, "R4 asleep after ack");
    bus_stop();
    check(asleep, 1, "R4 asleep held after stop");
    check(standby_ready, 0, "R8 not ready while asleep");
  endtask

  task automatic t_abort_first();
    logic a, e, l;
    bus_start();
    send_byte(8'hF9, a, e, l);
    check(a, 0, "R2 other first byte not acked");
    send_byte(dev_word(STRAP, 1'b0), a, e, l);
    check(a, 0, "R5 address after bad code not acked");
    bus_stop();
    check(asleep, 0, "R5 awake after bad code");
  endtask

  task automatic t_abort_addr();
    logic a, e, l;
    bus_start();
    send_byte(8'hF8, a, e, l);
    check(a, 1, "R2 entry code acked");
    send_byte(dev_word(3'b100, 1'b0), a, e, l);
    check(a, 0, "R3 wrong strap bits not acked");
    bus_start();
    send_byte(8'h86, a, e, l);
    check(a, 0, "R5 sleep code after bad address not acked");
    bus_stop();
    check(asleep, 0, "R5 awake after bad address");
    bus_start();
    send_byte(8'hF8, a, e, l);
    send_byte({4'b1011, STRAP, 1'b0}, a, e, l);
    check(a, 0, "R3 wrong upper nibble not acked");
    bus_stop();
  endtask

  task automatic t_abort_stop();
    logic a, e, l;
    bus_start();
    send_byte(8'hF8, a, e, l);
    send_byte(dev_word(STRAP, 1'b0), a, e, l);
    bus_stop();
    bus_start();
    send_byte(8'h86, a, e, l);
    check(a, 0, "R5 stop in place of repeated start aborts");
    bus_stop();
    check(asleep, 0, "R5 awake after stop abort");
  endtask

  task automatic t_abort_code();
    logic a, e, l;
    bus_start();
    send_byte(8'hF8, a, e, l);
    send_byte(dev_word(STRAP, 1'b0), a, e, l);
    bus_start();
    send_byte(8'h87, a, e, l);
    check(a, 0, "R5 wrong sleep code not acked");
    bus_stop();
    check(asleep, 0, "R5 awake after wrong sleep code");
  endtask

  task automatic t_sleep_mismatch();
    logic a, e, l;
    bus_start();
    send_byte(dev_word(3'b010, 1'b0), a, e, l);
    check(a, 0, "R6 mismatched address not acked");
    bus_stop();
    check(asleep, 1, "R6 mismatched address keeps sleep");
    check(recovering, 0, "R6 no recovery on mismatch");
  endtask

  task automatic t_wake(input logic rw, input logic busy);
    logic a, e, l;
    rec_seen = 0;
    bus_start();
    send_byte(dev_word(STRAP, rw), a, e, l);
    check(a, 0, "R6 wake access not acked");
    check(asleep, 0, "R7 sleep left on ninth rise");
    check(recovering, 1, "R7 recovering after wake");
    if (busy) begin
      bus_stop();
      bus_start();
      send_byte(8'hF8, a, e, l);
      check(a, 0, "R9 entry code ignored during recovery");
      bus_stop();
      check(recovering, 1, "R9 recovery still running");
    end
    for (int k = 0; k < 2 * REC && recovering; k++) wait_cyc(1);
    check(rec_seen, REC, "R7 R9 recovery length");
    check(standby_ready, 1, "R8 standby after recovery");
    check(asleep, 0, "R8 not asleep after recovery");
    if (!busy) bus_stop();
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_abort_first();
    t_abort_addr();
    t_abort_stop();
    t_abort_code();
    t_enter(1'b0);
    t_sleep_mismatch();
    t_wake(1'b1, 1'b0);
    t_enter(1'b1);
    t_wake(1'b0, 1'b1);
    t_enter(1'b0);
    t_wake(1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule